// File: doc/BRIEF.md
# Biphase Mark Receive Decoder

This block turns edge timestamps from a biphase-mark-coded line into data bits. Each `edge_vld` strobe carries an 8-bit timestamp from a free-running tick counter. The block measures the interval since the previous edge and classifies it as one half-bit cell (short) or a full bit cell (long). Intervals are measured modulo 256. The nominal half-bit is 4 ticks.

While hunting, the block shifts the short/long flag of every interval into a 32-bit search window. It watches that window for three exact patterns:

- the end of the preamble, which switches it to data decoding;
- a hard-reset ordered set;
- a cable-reset ordered set.

In data mode, intervals become bits in a 32-bit register. The bits are stored so that the oldest pending bit is read first. The consumer pulls fields of 1 to 32 bits with `rd_req`/`rd_len`.

A timeout pulse, a malformed interval, too many intervals, or too many unread bits all stop the decoder in an error state. Every end state (synchronised, hard reset, cable reset, error) holds until a `restart` pulse. That pulse clears all decoder state.

Top module: `bmc_rx_decoder`

## Requirements
- R1: The interval is the difference of two consecutive timestamps modulo 256. A step from 250 to 2 is therefore 8 ticks.
- R2: An interval of 1 to 6 ticks is short and an interval of 7 or more is long. In data mode, one long interval yields bit 0 and two consecutive short intervals yield bit 1.
- R3: In data mode, an interval of 0 ticks or of more than 12 ticks sets `err`. An interval of exactly 12 ticks decodes as bit 0.
- R4: In data mode, a short interval followed by a long interval sets `err`.
- R5: Bits are stored so that the oldest pending bit is read first. A read of N bits (1 to 32) returns the N oldest pending bits in `rd_data`, with the oldest bit at bit 0. `rd_ack` pulses in the cycle after the request, and `pend_cnt` drops by N.
- R6: A read request is ignored, with no `rd_ack` and `pend_cnt` unchanged, when N is 0, when N exceeds 32, or when N exceeds `pend_cnt`.
- R7: While hunting, each interval shifts its short flag (1 = short) into bit 31 of a 32-bit window that shifts right. After 32 intervals, interval k is therefore at bit k. When the window equals 0x36DB6DB6, `st_sync` is set, and data decoding starts with the next interval.
- R8: While hunting, a window value of 0xF33F3F3F sets `st_hrst`, and a value of 0x3C7FE0FF sets `st_crst`.
- R9: A `timeout` pulse while hunting or decoding sets `err`. A `timeout` pulse in a hard-reset, cable-reset or error state has no effect.
- R10: The flags `st_sync`, `st_hrst`, `st_crst` and `err` hold until `restart`. `restart` clears all four flags and `pend_cnt`, and returns the block to hunting. The first edge after `restart` only sets the timing reference.
- R11: The 858th interval after `restart` sets `err`, and the 857th does not.
- R12: A decoded bit that arrives when 32 bits are pending, in a cycle with no accepted read, sets `err`.
- R13: After reset, the block is hunting, all status flags are 0 and `pend_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Clear decoder state and resume hunting |
| edge_vld | input | 1 | An edge timestamp is presented |
| edge_ts | input | 8 | Free-running timestamp of the edge |
| timeout | input | 1 | Receive timeout pulse |
| rd_req | input | 1 | Request a field of decoded bits |
| rd_len | input | 6 | Field length in bits |
| rd_data | output | 32 | Field value, oldest bit at bit 0 |
| rd_ack | output | 1 | Field in `rd_data` is valid |
| st_sync | output | 1 | Preamble end found, decoding data |
| st_hrst | output | 1 | Hard-reset pattern seen |
| st_crst | output | 1 | Cable-reset pattern seen |
| err | output | 1 | Decoding aborted |
| pend_cnt | output | 6 | Decoded bits not yet read |

## Verification
Most internal faults show up at the ports within one clock of the edge that exposes them:

- A wrong interval class or a stale timestamp reference flips a status flag, or shifts the pending count, on the very next edge.
- A search window that is off by one bit misses all three patterns. After 32 intervals the block is then still hunting, with every flag low.
- A wrong shift or mask in the bit store returns a wrong `rd_data` in the cycle after the request.
- A miscounted fill level appears in `pend_cnt`. It also makes the overflow or the read-acceptance decision come one bit early or late.
- An off-by-one in the interval limit is visible only at interval 857 or 858.

// File: rtl/bmc_rx_pkg.sv
package bmc_rx_pkg;
  localparam int WIN_W = 32;
  localparam logic [WIN_W-1:0] PAT_SYNC = 32'h36DB6DB6;
  localparam logic [WIN_W-1:0] PAT_HRST = 32'hF33F3F3F;
  localparam logic [WIN_W-1:0] PAT_CRST = 32'h3C7FE0FF;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_DATA,
    ST_HRST,
    ST_CRST,
    ST_FAIL
  } rx_state_e;
endpackage

// File: rtl/bmc_ivl_class.sv
module bmc_ivl_class #(
  parameter int TS_W      = 8,
  parameter int SHORT_MAX = 6,
  parameter int LONG_MAX  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            edge_vld,
  input  logic [TS_W-1:0] edge_ts,
  output logic            ivl_vld,
  output logic            ivl_short,
  output logic            ivl_bad
);
  logic [TS_W-1:0] prev_q, prev_d, diff;
  logic            have_q, have_d;

  always_comb begin
    diff      = edge_ts - prev_q;
    ivl_vld   = edge_vld && have_q && !clr;
    ivl_short = diff <= TS_W'(SHORT_MAX);
    ivl_bad   = (diff == '0) || (diff > TS_W'(LONG_MAX));
    prev_d    = prev_q;
    have_d    = have_q;
    if (clr) begin
      have_d = 1'b0;
    end else if (edge_vld) begin
      prev_d = edge_ts;
      have_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      have_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      have_q <= have_d;
    end
  end
endmodule

// File: rtl/bmc_pattern_scan.sv
module bmc_pattern_scan
  import bmc_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic short_in,
  output logic hit_sync,
  output logic hit_hrst,
  output logic hit_crst
);
  logic [WIN_W-1:0] win_q, win_d, win_nx;

  always_comb begin
    win_nx   = {short_in, win_q[WIN_W-1:1]};
    hit_sync = (win_nx == PAT_SYNC);
    hit_hrst = (win_nx == PAT_HRST);
    hit_crst = (win_nx == PAT_CRST);
    if (clr)       win_d = '0;
    else if (step) win_d = win_nx;
    else           win_d = win_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end
endmodule

// File: rtl/bmc_bit_fifo.sv
module bmc_bit_fifo #(
  parameter int DW = 32,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          bit_vld,
  input  logic          bit_val,
  input  logic          rd_req,
  input  logic [CW-1:0] rd_len,
  output logic [DW-1:0] rd_data,
  output logic          rd_ack,
  output logic [CW-1:0] cnt,
  output logic          ovf
);
  logic [DW-1:0] sh_q, sh_d, data_q, data_d, mask, aligned;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ack_q, ack_d, rd_ok, push;

  always_comb begin
    for (int i = 0; i < DW; i++) mask[i] = (CW'(i) < rd_len);
    rd_ok   = rd_req && (rd_len != '0) && (rd_len <= CW'(DW)) && (rd_len <= cnt_q);
    aligned = sh_q >> (CW'(DW) - cnt_q);
    ovf     = bit_vld && (cnt_q == CW'(DW)) && !rd_ok;
    push    = bit_vld && !ovf;
    sh_d    = push ? {bit_val, sh_q[DW-1:1]} : sh_q;
    cnt_d   = cnt_q + CW'(push) - (rd_ok ? rd_len : '0);
    data_d  = rd_ok ? (aligned & mask) : data_q;
    ack_d   = rd_ok;
    if (clr) begin
      sh_d  = '0;
      cnt_d = '0;
      ack_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      data_q <= '0;
      ack_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      data_q <= data_d;
      ack_q  <= ack_d;
    end
  end

  assign rd_data = data_q;
  assign rd_ack  = ack_q;
  assign cnt     = cnt_q;

  // R12
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DW));
  // R5
  ack_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> $past(rd_req));
endmodule

// File: rtl/bmc_rx_decoder.sv
module bmc_rx_decoder
  import bmc_rx_pkg::*;
#(
  parameter int TS_W      = 8,
  parameter int SHORT_MAX = 6,
  parameter int LONG_MAX  = 12,
  parameter int DW        = 32,
  parameter int MAX_IVL   = 858
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       restart,
  input  logic                       edge_vld,
  input  logic [TS_W-1:0]            edge_ts,
  input  logic                       timeout,
  input  logic                       rd_req,
  input  logic [$clog2(DW+1)-1:0]    rd_len,
  output logic [DW-1:0]              rd_data,
  output logic                       rd_ack,
  output logic                       st_sync,
  output logic                       st_hrst,
  output logic                       st_crst,
  output logic                       err,
  output logic [$clog2(DW+1)-1:0]    pend_cnt
);
  localparam int CW = $clog2(DW+1);
  localparam int IW = $clog2(MAX_IVL+1);

  rx_state_e     state_q, state_pre, state_d;
  logic          half_q, half_d;
  logic [IW-1:0] icnt_q, icnt_d;
  logic          ivl_vld, ivl_short, ivl_bad, lim_hit;
  logic          hit_sync, hit_hrst, hit_crst, scan_step;
  logic          bit_vld, bit_val, fifo_ovf;

  bmc_ivl_class #(.TS_W(TS_W), .SHORT_MAX(SHORT_MAX), .LONG_MAX(LONG_MAX)) u_cls (
    .clk(clk), .rst_n(rst_n), .clr(restart), .edge_vld(edge_vld), .edge_ts(edge_ts),
    .ivl_vld(ivl_vld), .ivl_short(ivl_short), .ivl_bad(ivl_bad));

  bmc_pattern_scan u_scan (
    .clk(clk), .rst_n(rst_n), .clr(restart), .step(scan_step), .short_in(ivl_short),
    .hit_sync(hit_sync), .hit_hrst(hit_hrst), .hit_crst(hit_crst));

  bmc_bit_fifo #(.DW(DW), .CW(CW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(restart), .bit_vld(bit_vld), .bit_val(bit_val),
    .rd_req(rd_req), .rd_len(rd_len), .rd_data(rd_data), .rd_ack(rd_ack),
    .cnt(pend_cnt), .ovf(fifo_ovf));

  assign lim_hit = ivl_vld && (icnt_q == IW'(MAX_IVL-1));

  always_comb begin
    state_pre = state_q;
    half_d    = half_q;
    icnt_d    = icnt_q;
    bit_vld   = 1'b0;
    bit_val   = 1'b0;
    scan_step = 1'b0;
    if (restart) begin
      state_pre = ST_HUNT;
      half_d    = 1'b0;
      icnt_d    = '0;
    end else begin
      if (ivl_vld && (state_q == ST_HUNT || state_q == ST_DATA)) icnt_d = icnt_q + 1'b1;
      case (state_q)
        ST_HUNT: begin
          if (timeout || lim_hit) state_pre = ST_FAIL;
          else if (ivl_vld) begin
            scan_step = 1'b1;
            if (hit_sync)      state_pre = ST_DATA;
            else if (hit_hrst) state_pre = ST_HRST;
            else if (hit_crst) state_pre = ST_CRST;
          end
        end
        ST_DATA: begin
          if (timeout || lim_hit || (ivl_vld && ivl_bad)) state_pre = ST_FAIL;
          else if (ivl_vld) begin
            if (ivl_short) begin
              if (half_q) begin
                bit_vld = 1'b1;
                bit_val = 1'b1;
                half_d  = 1'b0;
              end else begin
                half_d = 1'b1;
              end
            end else if (half_q) begin
              state_pre = ST_FAIL;
            end else begin
              bit_vld = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    state_d = state_pre;
    if (fifo_ovf) state_d = ST_FAIL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      half_q  <= 1'b0;
      icnt_q  <= '0;
    end else begin
      state_q <= state_d;
      half_q  <= half_d;
      icnt_q  <= icnt_d;
    end
  end

  assign st_sync = (state_q == ST_DATA);
  assign st_hrst = (state_q == ST_HRST);
  assign st_crst = (state_q == ST_CRST);
  assign err     = (state_q == ST_FAIL);

  // R13
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_sync, st_hrst, st_crst, err}));
  // R7
  sync_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_sync) |-> $past(edge_vld));
  // R9
  timeout_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !restart && !st_hrst && !st_crst && !err) |=> err);
  // R10
  terminal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_hrst && !restart) |=> st_hrst);
endmodule

// File: tb/sim_bmc_rx_decoder.sv
module sim_bmc_rx_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, restart, edge_vld, timeout, rd_req;
  logic [7:0]  edge_ts, ts;
  logic [5:0]  rd_len, pend_cnt;
  logic [31:0] rd_data;
  logic        rd_ack, st_sync, st_hrst, st_crst, err;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bmc_rx_decoder u0 (
    .clk(clk), .rst_n(rst_n), .restart(restart), .edge_vld(edge_vld), .edge_ts(edge_ts),
    .timeout(timeout), .rd_req(rd_req), .rd_len(rd_len), .rd_data(rd_data), .rd_ack(rd_ack),
    .st_sync(st_sync), .st_hrst(st_hrst), .st_crst(st_crst), .err(err), .pend_cnt(pend_cnt));

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic edge_at(input int delta);
    ts = ts + 8'(delta);
    edge_ts = ts;
    edge_vld = 1'b1;
    @(negedge clk);
    edge_vld = 1'b0;
  endtask

  task automatic do_restart(input logic [7:0] base);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    ts = base;
    edge_ts = ts;
    edge_vld = 1'b1;
    @(negedge clk);
    edge_vld = 1'b0;
  endtask

  task automatic pattern(input logic [31:0] v);
    for (int k = 0; k < 32; k++) edge_at(v[k] ? 4 : 8);
  endtask

  task automatic rd(input int len, output logic [31:0] d, output logic a);
    rd_req = 1'b1;
    rd_len = 6'(len);
    @(negedge clk);
    rd_req = 1'b0;
    a = rd_ack;
    d = rd_data;
  endtask

  task automatic pulse_timeout();
    timeout = 1'b1;
    @(negedge clk);
    timeout = 1'b0;
  endtask

  task automatic t_reset();
    chk("R13 sync", st_sync, 0);
    chk("R13 hrst", st_hrst, 0);
    chk("R13 crst", st_crst, 0);
    chk("R13 err", err, 0);
    chk("R13 pend", pend_cnt, 0);
  endtask

  task automatic t_sync_read();
    logic [31:0] d; logic a;
    do_restart(8'd10);
    pattern(32'h36DB6DB6);
    chk("R7 sync set", st_sync, 1);
    chk("R7 no bits yet", pend_cnt, 0);
    edge_at(4); edge_at(4); edge_at(8); edge_at(4); edge_at(4);
    edge_at(4); edge_at(4); edge_at(8);
    chk("R2 five bits", pend_cnt, 5);
    rd(3, d, a);
    chk("R5 ack", a, 1);
    chk("R5 data", d, 32'h5);
    chk("R5 pend", pend_cnt, 2);
    rd(4, d, a);
    chk("R6 too long ack", a, 0);
    chk("R6 too long pend", pend_cnt, 2);
    rd(0, d, a);
    chk("R6 zero ack", a, 0);
    rd(33, d, a);
    chk("R6 over 32 ack", a, 0);
    chk("R6 pend kept", pend_cnt, 2);
    rd(2, d, a);
    chk("R5 second data", d, 32'h1);
    chk("R5 drained", pend_cnt, 0);
    chk("R5 no err", err, 0);
  endtask

  task automatic t_thresholds();
    logic [31:0] d; logic a;
    do_restart(8'd0);
    pattern(32'h36DB6DB6);
    edge_at(6); edge_at(6); edge_at(7); edge_at(12);
    chk("R2 six short seven long", pend_cnt, 3);
    chk("R3 twelve ok", err, 0);
    rd(3, d, a);
    chk("R2 bits 1,0,0", d, 32'h1);
    edge_at(13);
    chk("R3 thirteen err", err, 1);
    do_restart(8'd0);
    pattern(32'h36DB6DB6);
    edge_at(0);
    chk("R3 zero err", err, 1);
    do_restart(8'd0);
    pattern(32'h36DB6DB6);
    edge_at(4); edge_at(8);
    chk("R4 short long err", err, 1);
  endtask

  task automatic t_wrap();
    logic [31:0] d; logic a;
    do_restart(8'd74);
    pattern(32'h36DB6DB6);
    chk("R1 ts at 250", ts, 250);
    edge_at(8);
    chk("R1 wrap bit", pend_cnt, 1);
    chk("R1 wrap no err", err, 0);
    rd(1, d, a);
    chk("R1 wrap value", d, 0);
  endtask

  task automatic t_resets();
    do_restart(8'd3);
    pattern(32'hF33F3F3F);
    chk("R8 hard", st_hrst, 1);
    pulse_timeout();
    chk("R9 ignored in hard", err, 0);
    edge_at(8);
    chk("R10 hard holds", st_hrst, 1);
    do_restart(8'd3);
    chk("R10 cleared", st_hrst, 0);
    pattern(32'h3C7FE0FF);
    chk("R8 cable", st_crst, 1);
    chk("R8 not sync", st_sync, 0);
  endtask

  task automatic t_timeout();
    do_restart(8'd0);
    edge_at(4); edge_at(8);
    pulse_timeout();
    chk("R9 hunt timeout", err, 1);
    do_restart(8'd0);
    pattern(32'h36DB6DB6);
    edge_at(8);
    pulse_timeout();
    chk("R9 data timeout", err, 1);
  endtask

  task automatic t_restart();
    do_restart(8'd0);
    pattern(32'h36DB6DB6);
    edge_at(8); edge_at(8);
    do_restart(8'd99);
    chk("R10 pend cleared", pend_cnt, 0);
    chk("R10 sync cleared", st_sync, 0);
    chk("R10 ref edge only err", err, 0);
  endtask

  task automatic t_overflow();
    do_restart(8'd0);
    pattern(32'h36DB6DB6);
    for (int k = 0; k < 32; k++) edge_at(8);
    chk("R12 full", pend_cnt, 32);
    chk("R12 full no err", err, 0);
    edge_at(8);
    chk("R12 overflow err", err, 1);
  endtask

  task automatic t_limit();
    do_restart(8'd0);
    for (int k = 0; k < 857; k++) edge_at(8);
    chk("R11 857 ok", err, 0);
    edge_at(8);
    chk("R11 858 err", err, 1);
  endtask

  initial begin
    rst_n = 1'b0; restart = 1'b0; edge_vld = 1'b0; edge_ts = '0; ts = '0;
    timeout = 1'b0; rd_req = 1'b0; rd_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sync_read();
    t_thresholds();
    t_wrap();
    t_resets();
    t_timeout();
    t_restart();
    t_overflow();
    t_limit();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule